// File: doc/BRIEF.md
# Nonvolatile Byte Store Register Controller

This block sits in the I/O space of a small processor core and gives software byte access to a 512-location nonvolatile store. Software places a 9-bit location in two address registers. It places a byte in a data register, then starts an access through a control register. The store itself is modelled as an internal array of registers. Cell physics and supply supervision are not modelled.

A write must be armed before it can start. Software first sets the arm bit, which stays set for a few cycles. Only a write-enable request made while the arm bit is still set starts a write. The write then runs on its own timer for `WRITE_CYCLES` clock cycles. Throughout that time the write-enable bit reads back as 1, so software can poll it to learn when the next byte may be written. A read is started by setting the read-enable bit, and the fetched byte lands in the data register. Each access raises a stall request to the core for a fixed number of cycles: a short one for a write and a longer one for a read.

The register interface is a plain single-cycle I/O bus with no handshake. Register writes are taken on the clock edge where `io_we` is high. `io_rdata` is a combinational view of the register selected by `io_addr`. The core must issue no register write while `cpu_hold` is high.

Top module: `nvs_io_ctrl`

## Requirements
- R1: After reset every register reads 0x00, and `cpu_hold` is low.
- R2: The low address register (I/O 0x1E) holds location bits 7..0. Bit 0 of the high address register (I/O 0x1F) holds location bit 8, and its bits 7..1 always read 0. Bits 7..3 of the control register (I/O 0x1C) always read 0.
- R3: Writing 1 to control bit 2 (arm) while the block is idle makes bit 2 read 1 for exactly 4 cycles after the write edge. Hardware then clears it.
- R4: A write to control bit 1 (write enable) starts a write only if the arm bit was already set before that bus write. Otherwise the write is ignored: bit 1 reads 0, `cpu_hold` stays low and the store is unchanged. Writing 0x06 from idle therefore arms the block but starts nothing.
- R5: A started write keeps control bit 1 at 1 for exactly `WRITE_CYCLES` cycles and then clears it. When the write completes, the store holds the data register's byte at the address that was current when the write started. Starting a write clears the arm bit.
- R6: `cpu_hold` is high for exactly 2 cycles after the edge that starts a write.
- R7: Writing 1 to control bit 0 (read enable) while idle sets `cpu_hold` for exactly 4 cycles. Bit 0 reads 1 for one cycle and then 0. Afterwards the data register (I/O 0x1D) holds the stored byte at the current address.
- R8: While a write is in progress, bus writes to the address, data and control registers are all ignored. No read starts and no arm is set.
- R9: When a single control write sets both write enable and read enable while armed, only the write starts. The stall lasts 2 cycles and the data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 6 | I/O register address |
| io_we | input | 1 | Register write strobe, taken at the clock edge |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Read view of the register at `io_addr` |
| cpu_hold | output | 1 | Stall request to the processor core |

## Verification
The checker takes for granted that the core honours the stall. No register write arrives while `cpu_hold` is high, so a new access can never begin inside the stall of an earlier read. The stall-length counters rely on this. The bench keeps to that rule by stepping through every stall before it issues the next bus write. Its attempts to disturb a running write are placed only after the 2-cycle write stall has ended, inside the busy window.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  // control register bit positions (decoded by software)
  localparam int CTL_RD_BIT  = 0;
  localparam int CTL_WR_BIT  = 1;
  localparam int CTL_ARM_BIT = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ADDR_HI,
    SEL_ADDR_LO,
    SEL_DATA,
    SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/nvs_decode.sv
module nvs_decode
  import nvs_pkg::*;
#(
  parameter int IO_AW = 6,
  parameter logic [IO_AW-1:0] LOC_ADDR_HI = 6'h1F,
  parameter logic [IO_AW-1:0] LOC_ADDR_LO = 6'h1E,
  parameter logic [IO_AW-1:0] LOC_DATA    = 6'h1D,
  parameter logic [IO_AW-1:0] LOC_CTRL    = 6'h1C
) (
  input  logic [IO_AW-1:0] io_addr,
  output reg_sel_e         sel
);
  always_comb begin
    if (io_addr == LOC_ADDR_HI)      sel = SEL_ADDR_HI;
    else if (io_addr == LOC_ADDR_LO) sel = SEL_ADDR_LO;
    else if (io_addr == LOC_DATA)    sel = SEL_DATA;
    else if (io_addr == LOC_CTRL)    sel = SEL_CTRL;
    else                             sel = SEL_NONE;
  end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq #(
  parameter int ARM_CYCLES   = 4,
  parameter int WRITE_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,     // bus write to control register
  input  logic req_arm,
  input  logic req_wr,
  input  logic req_rd,
  output logic arm,
  output logic wr_busy,
  output logic rd_pend,
  output logic lock,
  output logic wr_start,
  output logic rd_start,
  output logic wr_done
);
  localparam int AW = $clog2(ARM_CYCLES + 1);
  localparam int BW = $clog2(WRITE_CYCLES + 1);
  localparam logic [AW-1:0] ARM_LOAD  = AW'(ARM_CYCLES);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(WRITE_CYCLES);
  localparam logic [BW-1:0] BUSY_LAST = BW'(1);

  logic [AW-1:0] arm_cnt;
  logic [BW-1:0] busy_cnt;
  logic          arm_set;

  assign arm     = (arm_cnt != '0);
  assign wr_busy = (busy_cnt != '0);
  assign lock    = wr_busy | rd_pend;

  // guarded start: arm must already be live before this bus write
  assign wr_start = ctl_we & req_wr & arm & ~lock;
  assign rd_start = ctl_we & req_rd & ~lock & ~wr_start;
  assign arm_set  = ctl_we & req_arm & ~lock & ~wr_start;
  assign wr_done  = (busy_cnt == BUSY_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt <= '0;
    end else if (wr_start) begin
      arm_cnt <= '0;
    end else if (arm_set) begin
      arm_cnt <= ARM_LOAD;
    end else if (arm) begin
      arm_cnt <= arm_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (wr_start) begin
      busy_cnt <= BUSY_LOAD;
    end else if (wr_busy) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= rd_start;
  end
endmodule

// File: rtl/nvs_stall.sv
module nvs_stall #(
  parameter int WR_STALL = 2,
  parameter int RD_STALL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_start,
  input  logic rd_start,
  output logic hold
);
  localparam int MAXS = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;
  localparam int HW   = $clog2(MAXS + 1);
  localparam logic [HW-1:0] WR_LOAD = HW'(WR_STALL);
  localparam logic [HW-1:0] RD_LOAD = HW'(RD_STALL);

  logic [HW-1:0] cnt;

  assign hold = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (wr_start) cnt <= WR_LOAD;
    else if (rd_start) cnt <= RD_LOAD;
    else if (hold)     cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/nvs_store.sv
module nvs_store #(
  parameter int ADDR_BITS = 9
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/nvs_io_ctrl.sv
module nvs_io_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_BITS    = 9,
  parameter int IO_AW        = 6,
  parameter int ARM_CYCLES   = 4,
  parameter int WRITE_CYCLES = 10000,
  parameter int WR_STALL     = 2,
  parameter int RD_STALL     = 4,
  parameter logic [IO_AW-1:0] LOC_ADDR_HI = 6'h1F,
  parameter logic [IO_AW-1:0] LOC_ADDR_LO = 6'h1E,
  parameter logic [IO_AW-1:0] LOC_DATA    = 6'h1D,
  parameter logic [IO_AW-1:0] LOC_CTRL    = 6'h1C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_we,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic             cpu_hold
);
  localparam int HI_W = ADDR_BITS - 8;

  reg_sel_e             sel;
  logic [ADDR_BITS-1:0] addr_q;
  logic [7:0]           data_q;
  logic [7:0]           store_rd;
  logic [15:0]          addr_ext;
  logic arm, wr_busy, rd_pend, lock, wr_start, rd_start, wr_done;

  nvs_decode #(
    .IO_AW(IO_AW), .LOC_ADDR_HI(LOC_ADDR_HI), .LOC_ADDR_LO(LOC_ADDR_LO),
    .LOC_DATA(LOC_DATA), .LOC_CTRL(LOC_CTRL)
  ) u_dec (
    .io_addr(io_addr),
    .sel    (sel)
  );

  nvs_seq #(.ARM_CYCLES(ARM_CYCLES), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_we  (io_we && (sel == SEL_CTRL)),
    .req_arm (io_wdata[CTL_ARM_BIT]),
    .req_wr  (io_wdata[CTL_WR_BIT]),
    .req_rd  (io_wdata[CTL_RD_BIT]),
    .arm     (arm),
    .wr_busy (wr_busy),
    .rd_pend (rd_pend),
    .lock    (lock),
    .wr_start(wr_start),
    .rd_start(rd_start),
    .wr_done (wr_done)
  );

  nvs_stall #(.WR_STALL(WR_STALL), .RD_STALL(RD_STALL)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_start(wr_start),
    .rd_start(rd_start),
    .hold    (cpu_hold)
  );

  nvs_store #(.ADDR_BITS(ADDR_BITS)) u_store (
    .clk  (clk),
    .we   (wr_done),
    .addr (addr_q),
    .wdata(data_q),
    .rdata(store_rd)
  );

  // address register: high part and low part, frozen while locked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (io_we && !lock) begin
      if (sel == SEL_ADDR_HI) addr_q[ADDR_BITS-1:8] <= io_wdata[HI_W-1:0];
      if (sel == SEL_ADDR_LO) addr_q[7:0] <= io_wdata;
    end
  end

  // data register: bus write when unlocked, fetched byte when read lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_pend) begin
      data_q <= store_rd;
    end else if (io_we && !lock && (sel == SEL_DATA)) begin
      data_q <= io_wdata;
    end
  end

  assign addr_ext = 16'(addr_q);

  always_comb begin
    io_rdata = '0;
    case (sel)
      SEL_ADDR_HI: io_rdata = addr_ext[15:8];
      SEL_ADDR_LO: io_rdata = addr_ext[7:0];
      SEL_DATA:    io_rdata = data_q;
      SEL_CTRL: begin
        io_rdata[CTL_ARM_BIT] = arm;
        io_rdata[CTL_WR_BIT]  = wr_busy;
        io_rdata[CTL_RD_BIT]  = rd_pend;
      end
      default:     io_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nvs_io_ctrl_chk.sv
module nvs_io_ctrl_chk #(
  parameter int ADDR_BITS    = 9,
  parameter int IO_AW        = 6,
  parameter int ARM_CYCLES   = 4,
  parameter int WRITE_CYCLES = 10000,
  parameter int WR_STALL     = 2,
  parameter int RD_STALL     = 4,
  parameter logic [IO_AW-1:0] LOC_CTRL = 6'h1C
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [IO_AW-1:0]     io_addr,
  input logic                 io_we,
  input logic [7:0]           io_wdata,
  input logic                 cpu_hold,
  input logic                 arm,
  input logic                 wr_busy,
  input logic                 rd_pend,
  input logic [ADDR_BITS-1:0] addr_q,
  input logic [7:0]           data_q
);
  localparam int MAXS = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;

  int arm_run, busy_run, hold_run;
  logic arm_poke;

  assign arm_poke = io_we && (io_addr == LOC_CTRL) && io_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_run  <= 0;
      busy_run <= 0;
      hold_run <= 0;
    end else begin
      arm_run  <= (!arm || arm_poke) ? 0 : arm_run + 1;
      busy_run <= wr_busy ? busy_run + 1 : 0;
      hold_run <= cpu_hold ? hold_run + 1 : 0;
    end
  end

  // R3: arm never outlives its window
  assert_arm_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (arm_run < ARM_CYCLES));

  // R4: a write only begins while armed
  assert_start_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(arm));

  // R5: the busy window has exactly the configured length
  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_busy) |-> (busy_run == WRITE_CYCLES));

  assert_busy_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> (busy_run < WRITE_CYCLES));

  // R6: a write start raises the stall at once
  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> cpu_hold);

  // R7: a read start raises the stall, and no stall exceeds the longest
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_pend) |-> cpu_hold);

  assert_hold_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hold |-> (hold_run < MAXS));

  // R8: address and data are frozen during a write, and no read runs
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && $past(wr_busy)) |-> ($stable(addr_q) && $stable(data_q)));

  assert_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !rd_pend);
endmodule

bind nvs_io_ctrl nvs_io_ctrl_chk #(
  .ADDR_BITS(ADDR_BITS), .IO_AW(IO_AW), .ARM_CYCLES(ARM_CYCLES),
  .WRITE_CYCLES(WRITE_CYCLES), .WR_STALL(WR_STALL), .RD_STALL(RD_STALL),
  .LOC_CTRL(LOC_CTRL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
  .io_wdata(io_wdata), .cpu_hold(cpu_hold), .arm(arm), .wr_busy(wr_busy),
  .rd_pend(rd_pend), .addr_q(addr_q), .data_q(data_q)
);

// File: tb/tb_nvs_io_ctrl.sv
module tb_nvs_io_ctrl;
  localparam int WCYC = 20;
  localparam logic [5:0] A_HI = 6'h1F, A_LO = 6'h1E, A_DAT = 6'h1D, A_CTL = 6'h1C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] io_addr = '0;
  logic       io_we = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       cpu_hold;

  int checks = 0;
  int fails  = 0;

  logic [7:0] model [512];
  bit         written [512];
  logic [8:0] m_addr = '0;
  logic [7:0] m_data = '0;

  always #2 clk = ~clk;   // 250 MHz

  nvs_io_ctrl #(.WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_hold(cpu_hold)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // caller stands at a negedge; returns at the negedge after the write edge
  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_we = 1'b1;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [7:0] d);
    io_addr = a;
    #0.5;
    d = io_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_hi(input logic [8:0] a);
    return {7'b0, a[8]};
  endfunction

  task automatic set_loc(input logic [8:0] a, input logic [7:0] d);
    bus_wr(A_HI, {7'b0, a[8]});
    bus_wr(A_LO, a[7:0]);
    bus_wr(A_DAT, d);
    m_addr = a; m_data = d;
  endtask

  // full guarded write, disturbance attempts inside the busy window
  task automatic do_write(input logic [8:0] a, input logic [7:0] d, input logic [7:0] cmd);
    logic [7:0] r;
    int k;
    set_loc(a, d);
    bus_wr(A_CTL, 8'h04);
    bus_rd(A_CTL, r); chk("R3 arm set", r[2], 1'b1);
    bus_wr(A_CTL, cmd);
    k = 0;
    for (int g = 0; g < WCYC + 10; g++) begin
      bus_rd(A_CTL, r);
      if (!r[1]) break;
      if (k == 0) chk("R5 arm cleared at start", r[2], 1'b0);
      if (k < 3) chk("R6 write stall", cpu_hold, (k < 2));
      if (k == 0 && cmd[0]) chk("R9 no read with write", r[0], 1'b0);
      k++;
      case (k)
        5: bus_wr(A_LO, ~a[7:0]);
        6: bus_wr(A_DAT, ~d);
        7: bus_wr(A_CTL, 8'h01);
        8: bus_wr(A_CTL, 8'h04);
        9: bus_wr(A_HI, {7'b0, ~a[8]});
        default: step(1);
      endcase
    end
    chk("R5 busy length", k, WCYC);
    model[a] = d; written[a] = 1'b1;
    bus_rd(A_LO, r);  chk("R8 low addr frozen", r, a[7:0]);
    bus_rd(A_HI, r);  chk("R8 high addr frozen", r, exp_hi(a));
    bus_rd(A_DAT, r); chk("R8 data frozen", r, d);
    bus_rd(A_CTL, r); chk("R8 no arm or read after busy", r, 8'h00);
  endtask

  task automatic do_read(input logic [8:0] a);
    logic [7:0] r;
    bus_wr(A_HI, {7'b0, a[8]});
    bus_wr(A_LO, a[7:0]);
    bus_wr(A_CTL, 8'h01);
    bus_rd(A_CTL, r); chk("R7 read bit visible", r, 8'h01);
    for (int i = 0; i < 5; i++) begin
      chk("R7 read stall", cpu_hold, (i < 4));
      step(1);
    end
    bus_rd(A_CTL, r); chk("R7 read bit cleared", r, 8'h00);
    bus_rd(A_DAT, r); chk("R7 fetched byte", r, model[a]);
    m_addr = a; m_data = model[a];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [8:0] a;
    void'($urandom(32'h1C0FFEE));
    step(3);
    rst_n = 1'b1;
    step(1);

    // reset state
    bus_rd(A_HI, r);  chk("R1 high addr reset", r, 8'h00);
    bus_rd(A_LO, r);  chk("R1 low addr reset", r, 8'h00);
    bus_rd(A_DAT, r); chk("R1 data reset", r, 8'h00);
    bus_rd(A_CTL, r); chk("R1 ctrl reset", r, 8'h00);
    chk("R1 hold reset", cpu_hold, 1'b0);

    // field layout
    bus_wr(A_HI, 8'hFF);
    bus_rd(A_HI, r);  chk("R2 high addr upper bits zero", r, 8'h01);
    bus_wr(A_LO, 8'hA5);
    bus_rd(A_LO, r);  chk("R2 low addr", r, 8'hA5);
    bus_wr(A_CTL, 8'hF8);
    bus_rd(A_CTL, r); chk("R2 ctrl reserved zero", r, 8'h00);

    // arm window length
    bus_wr(A_CTL, 8'h04);
    for (int i = 0; i < 6; i++) begin
      bus_rd(A_CTL, r);
      chk("R3 arm window", r[2], (i < 4));
      step(1);
    end

    // write enable without arm
    bus_wr(A_CTL, 8'h02);
    bus_rd(A_CTL, r); chk("R4 unarmed write ignored", r, 8'h00);
    chk("R4 unarmed no stall", cpu_hold, 1'b0);

    // combined arm+write from idle only arms
    bus_wr(A_CTL, 8'h06);
    bus_rd(A_CTL, r); chk("R4 combined 0x06 only arms", r, 8'h04);
    chk("R4 combined no stall", cpu_hold, 1'b0);
    step(6);

    // arm that expired
    bus_wr(A_CTL, 8'h04);
    step(5);
    bus_wr(A_CTL, 8'h02);
    bus_rd(A_CTL, r); chk("R4 expired arm ignored", r, 8'h00);

    // directed writes at the ends and reads back
    do_write(9'h000, 8'h3C, 8'h02);
    do_write(9'h1FF, 8'hC3, 8'h02);
    do_write(9'h100, 8'h5A, 8'h03);   // write and read together
    do_read(9'h1FF);
    do_read(9'h000);
    do_read(9'h100);

    // unarmed write leaves stored byte alone
    set_loc(9'h1FF, 8'h00);
    bus_wr(A_CTL, 8'h02);
    step(WCYC + 2);
    do_read(9'h1FF);

    // constrained random traffic
    for (int it = 0; it < 40; it++) begin
      a = 9'($urandom % 512);
      case ($urandom % 3)
        0: do_write(a, 8'($urandom), ($urandom % 2) ? 8'h02 : 8'h03);
        1: begin
          if (!written[a]) a = m_addr;
          if (written[a]) do_read(a);
        end
        default: begin
          set_loc(a, 8'($urandom));
          bus_wr(A_CTL, 8'h02);
          bus_rd(A_CTL, r); chk("R4 random unarmed ignored", r, 8'h00);
          chk("R4 random unarmed no stall", cpu_hold, 1'b0);
        end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule